// File: doc/BRIEF.md
# Symmetric Five-Segment Vector Sequencer

This block plays out a fixed-length switching period for a three-phase multilevel converter as a symmetric pattern of five segments: first vector, second vector, third vector, second vector, first vector. Each vector is a triple of per-phase level codes (0 to 4). An upstream controller writes one command per period through a valid/ready port. A command holds three vectors and three duty counts. The block stores the command in a single shadow slot and makes it active only when the next period starts. During a period it presents the current level triple for the per-phase switch selectors, together with the index of the running segment.

At every period start the block also reports how many phases change level across the seam, that is, between the last state of the old period and the first state of the new one. It also flags a command whose neighbouring vectors are not a single one-level step in a single phase.

Back-pressure works as follows. `cmd_ready` is high while the shadow slot is empty. A command is taken on a cycle where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` then stays low until the period boundary moves the slot into the active program. A producer that holds `cmd_valid` high waits through that time, and its command is taken in the first cycle of the new period. Commands are never dropped, and the producer may change the payload only after acceptance.

Top module: `seq5_sequencer`

## Requirements
- R1: After reset the active program has all-zero vectors with the whole period in the middle segment: `lvl_out`=0, `seg_idx`=2, `xfer_cnt`=0, `seq_err`=0, `cmd_ready`=1 and `period_start`=1 in the first cycle.
- R2: `period_start` is high for exactly one cycle out of every PERIOD cycles, in the first cycle of each period.
- R3: Within a period `seg_idx` runs through 0,1,2,3,4, skipping segments of zero length. `lvl_out` shows the first vector in segments 0 and 4, the second vector in segments 1 and 3, and the third vector in segment 2.
- R4: With effective duties e1, e2 and e3, the segment lengths are floor(e1/2), floor(e2/2), e3, e2-floor(e2/2) and e1-floor(e1/2).
- R5: The duties are normalised as follows: e1=min(d1,PERIOD), e2=min(d2,PERIOD-e1), and e3=PERIOD-e1-e2. As a result, e3 equals d3 whenever d1+d2+d3=PERIOD.
- R6: An accepted command takes effect at the first period start after acceptance. The period in which it is accepted plays out unchanged.
- R7: `cmd_ready` falls in the cycle after acceptance and rises again only in the first cycle of a period. A command held valid during that time is accepted in the first cycle of the new period.
- R8: When no command is pending at a boundary, the previous program repeats.
- R9: At each period start, `xfer_cnt` becomes the number of phases whose level differs between the last state of the old period and the first state of the new period. It then holds for the whole period.
- R10: `seq_err` is 1 for every period whose program has a level code above 4, or whose first/second or second/third vectors do not differ in exactly one phase by exactly one level. It changes only at a period start.
- R11: Phase p of a vector or of `lvl_out` sits at bits [3p+2:3p]. Level codes 0..4 stand for the five output levels from lowest to highest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Shadow slot empty, command can be taken |
| cmd_vec1 | input | 3*PHASES | First vector (outer segments) |
| cmd_vec2 | input | 3*PHASES | Second vector (segments 1 and 3) |
| cmd_vec3 | input | 3*PHASES | Third vector (middle segment) |
| cmd_dur1 | input | clog2(PERIOD+1) | Duty count of first vector |
| cmd_dur2 | input | clog2(PERIOD+1) | Duty count of second vector |
| cmd_dur3 | input | clog2(PERIOD+1) | Duty count of third vector |
| lvl_out | output | 3*PHASES | Current per-phase level triple |
| seg_idx | output | 3 | Running segment, 0..4 |
| period_start | output | 1 | First cycle of a period |
| xfer_cnt | output | clog2(PHASES+1) | Phases changing level across the last seam |
| seq_err | output | 1 | Active program breaks the adjacency rule |

## Verification
The bench builds the block with PERIOD=40 and PHASES=3. The short period lets several dozen full periods be compared cycle by cycle against a model of the segment layout. Because the duty ports are then 6 bits wide, random duties up to 63 can exceed the period, so the clipping of R5 comes up often alongside exact-sum and short-sum commands. The directed cases cover odd duties, empty outer segments, level jumps, an out-of-range code, a skipped command slot and a command that is held while the slot is full.

// File: rtl/seq5_pkg.sv
package seq5_pkg;
  localparam int LVL_W   = 3;
  localparam int LVL_TOP = 4;

  typedef enum logic [2:0] {
    SEG_OUT_LEAD  = 3'd0,
    SEG_MID_LEAD  = 3'd1,
    SEG_CENTRE    = 3'd2,
    SEG_MID_TRAIL = 3'd3,
    SEG_OUT_TRAIL = 3'd4
  } seg_e;
endpackage

// File: rtl/seq5_duty_norm.sv
// Clips the three duty counts to one period and turns them into the
// four segment end positions of the symmetric pattern.
module seq5_duty_norm #(
  parameter int PERIOD = 50000,
  parameter int DW     = 16
) (
  input  logic [DW-1:0] dur1,
  input  logic [DW-1:0] dur2,
  input  logic [DW-1:0] dur3,
  output logic [DW-1:0] bnd1,
  output logic [DW-1:0] bnd2,
  output logic [DW-1:0] bnd3,
  output logic [DW-1:0] bnd4
);
  localparam int EW = DW + 2;
  localparam logic [DW-1:0] P_D = DW'(PERIOD);
  localparam logic [EW-1:0] P_E = EW'(PERIOD);

  logic [DW-1:0] e1, e2, e3, room, h1, h2;
  logic [EW-1:0] total;

  always_comb begin
    e1    = (dur1 > P_D) ? P_D : dur1;
    room  = P_D - e1;
    e2    = (dur2 > room) ? room : dur2;
    total = {2'b00, e1} + {2'b00, e2} + {2'b00, dur3};
    // third duty is kept when consistent, otherwise it absorbs the rest
    e3    = (total == P_E) ? dur3 : (room - e2);
    h1    = e1 >> 1;
    h2    = e2 >> 1;
    bnd1  = h1;
    bnd2  = h1 + h2;
    bnd3  = bnd2 + e3;
    bnd4  = bnd3 + (e2 - h2);
  end
endmodule

// File: rtl/seq5_adj_check.sv
// Flags whether two vectors form one legal step: every code in range,
// exactly one phase different, and that phase moving by one level.
module seq5_adj_check #(
  parameter int PHASES = 3,
  parameter int LW     = 3
) (
  input  logic [PHASES*LW-1:0] vx,
  input  logic [PHASES*LW-1:0] vy,
  output logic                 ok
);
  import seq5_pkg::*;

  always_comb begin
    int          nd;
    logic        bad;
    logic [LW:0] lx, ly;
    nd  = 0;
    bad = 1'b0;
    for (int p = 0; p < PHASES; p++) begin
      lx = {1'b0, vx[p*LW +: LW]};
      ly = {1'b0, vy[p*LW +: LW]};
      if (lx > (LW+1)'(LVL_TOP) || ly > (LW+1)'(LVL_TOP)) bad = 1'b1;
      if (lx != ly) begin
        nd = nd + 1;
        if ((lx + 1'b1 != ly) && (ly + 1'b1 != lx)) bad = 1'b1;
      end
    end
    ok = !bad && (nd == 1);
  end
endmodule

// File: rtl/seq5_seg_decode.sv
// Maps the period position onto a segment and the vector shown there.
module seq5_seg_decode #(
  parameter int PHASES = 3,
  parameter int LW     = 3,
  parameter int DW     = 16,
  parameter int CW     = 16
) (
  input  logic [PHASES*LW-1:0] va,
  input  logic [PHASES*LW-1:0] vb,
  input  logic [PHASES*LW-1:0] vc,
  input  logic [DW-1:0]        b1,
  input  logic [DW-1:0]        b2,
  input  logic [DW-1:0]        b3,
  input  logic [DW-1:0]        b4,
  input  logic [CW-1:0]        pos,
  output logic [PHASES*LW-1:0] vout,
  output seq5_pkg::seg_e       seg
);
  import seq5_pkg::*;

  logic [DW-1:0] p;
  assign p = DW'(pos);

  always_comb begin
    if (p < b1)      seg = SEG_OUT_LEAD;
    else if (p < b2) seg = SEG_MID_LEAD;
    else if (p < b3) seg = SEG_CENTRE;
    else if (p < b4) seg = SEG_MID_TRAIL;
    else             seg = SEG_OUT_TRAIL;
  end

  always_comb begin
    unique case (seg)
      SEG_MID_LEAD, SEG_MID_TRAIL: vout = vb;
      SEG_CENTRE:                  vout = vc;
      default:                     vout = va;
    endcase
  end
endmodule

// File: rtl/seq5_sequencer.sv
module seq5_sequencer #(
  parameter int PHASES = 3,
  parameter int PERIOD = 50000
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   cmd_valid,
  output logic                                   cmd_ready,
  input  logic [PHASES*seq5_pkg::LVL_W-1:0]      cmd_vec1,
  input  logic [PHASES*seq5_pkg::LVL_W-1:0]      cmd_vec2,
  input  logic [PHASES*seq5_pkg::LVL_W-1:0]      cmd_vec3,
  input  logic [$clog2(PERIOD+1)-1:0]            cmd_dur1,
  input  logic [$clog2(PERIOD+1)-1:0]            cmd_dur2,
  input  logic [$clog2(PERIOD+1)-1:0]            cmd_dur3,
  output logic [PHASES*seq5_pkg::LVL_W-1:0]      lvl_out,
  output logic [2:0]                             seg_idx,
  output logic                                   period_start,
  output logic [$clog2(PHASES+1)-1:0]            xfer_cnt,
  output logic                                   seq_err
);
  import seq5_pkg::*;

  localparam int LW = LVL_W;
  localparam int VW = PHASES * LW;
  localparam int CW = $clog2(PERIOD);
  localparam int DW = $clog2(PERIOD + 1);
  localparam int XW = $clog2(PHASES + 1);
  localparam int NPAIR = 2;

  typedef struct packed {
    logic [VW-1:0] va;
    logic [VW-1:0] vb;
    logic [VW-1:0] vc;
    logic [DW-1:0] b1;
    logic [DW-1:0] b2;
    logic [DW-1:0] b3;
    logic [DW-1:0] b4;
    logic          err;
  } prog_t;

  localparam prog_t RST_PROG = '{
    va: '0, vb: '0, vc: '0,
    b1: '0, b2: '0, b3: DW'(PERIOD), b4: DW'(PERIOD),
    err: 1'b0
  };

  logic [CW-1:0] cnt;
  logic          wrap;
  logic          pend;
  logic          acc;
  prog_t         sh_q, act_q, nxt_prog, in_prog;
  logic [VW-1:0] first_vec;
  logic [XW-1:0] xfer_d, xfer_q;
  seg_e          seg_cur;
  logic [NPAIR-1:0] pair_ok;
  logic [VW-1:0] pair_lo [NPAIR];
  logic [VW-1:0] pair_hi [NPAIR];

  // ---- command intake -------------------------------------------------
  assign acc = cmd_valid && !pend;

  seq5_duty_norm #(.PERIOD(PERIOD), .DW(DW)) u_norm (
    .dur1 (cmd_dur1),
    .dur2 (cmd_dur2),
    .dur3 (cmd_dur3),
    .bnd1 (in_prog.b1),
    .bnd2 (in_prog.b2),
    .bnd3 (in_prog.b3),
    .bnd4 (in_prog.b4)
  );

  assign pair_lo[0] = cmd_vec1;
  assign pair_hi[0] = cmd_vec2;
  assign pair_lo[1] = cmd_vec2;
  assign pair_hi[1] = cmd_vec3;

  for (genvar g = 0; g < NPAIR; g++) begin : g_pair
    seq5_adj_check #(.PHASES(PHASES), .LW(LW)) u_adj (
      .vx (pair_lo[g]),
      .vy (pair_hi[g]),
      .ok (pair_ok[g])
    );
  end

  assign in_prog.va  = cmd_vec1;
  assign in_prog.vb  = cmd_vec2;
  assign in_prog.vc  = cmd_vec3;
  assign in_prog.err = ~&pair_ok;

  // ---- period timing and program swap ---------------------------------
  assign wrap     = (cnt == CW'(PERIOD - 1));
  assign nxt_prog = pend ? sh_q : act_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      pend   <= 1'b0;
      sh_q   <= RST_PROG;
      act_q  <= RST_PROG;
      xfer_q <= '0;
    end else begin
      cnt <= wrap ? '0 : cnt + CW'(1);
      if (acc) begin
        sh_q <= in_prog;
        pend <= 1'b1;
      end else if (wrap) begin
        pend <= 1'b0;
      end
      if (wrap) begin
        act_q  <= nxt_prog;
        xfer_q <= xfer_d;
      end
    end
  end

  // ---- output decode --------------------------------------------------
  seq5_seg_decode #(.PHASES(PHASES), .LW(LW), .DW(DW), .CW(CW)) u_dec (
    .va   (act_q.va),
    .vb   (act_q.vb),
    .vc   (act_q.vc),
    .b1   (act_q.b1),
    .b2   (act_q.b2),
    .b3   (act_q.b3),
    .b4   (act_q.b4),
    .pos  (cnt),
    .vout (lvl_out),
    .seg  (seg_cur)
  );

  // first state of the coming period: first non-empty segment
  always_comb begin
    if (nxt_prog.b1 != '0)      first_vec = nxt_prog.va;
    else if (nxt_prog.b2 != '0) first_vec = nxt_prog.vb;
    else                        first_vec = nxt_prog.vc;
  end

  // phases whose level changes across the seam
  always_comb begin
    int n;
    n = 0;
    for (int p = 0; p < PHASES; p++) begin
      if (lvl_out[p*LW +: LW] != first_vec[p*LW +: LW]) n = n + 1;
    end
    xfer_d = XW'(n);
  end

  assign seg_idx      = seg_cur;
  assign period_start = (cnt == '0);
  assign cmd_ready    = !pend;
  assign xfer_cnt     = xfer_q;
  assign seq_err      = act_q.err;
endmodule

// File: rtl/seq5_sequencer_chk.sv
module seq5_sequencer_chk #(
  parameter int PHASES = 3,
  parameter int VW     = 9,
  parameter int XW     = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic          period_start,
  input logic [2:0]    seg_idx,
  input logic [VW-1:0] lvl_out,
  input logic [XW-1:0] xfer_cnt,
  input logic          seq_err
);
  // R2
  strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    period_start |=> !period_start);

  // R3
  seg_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seg_idx <= 3'd4);

  // R3
  seg_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !period_start |-> seg_idx >= $past(seg_idx));

  // R3
  lvl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!period_start && $stable(seg_idx)) |-> $stable(lvl_out));

  // R7
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_ready);

  // R7
  ready_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_ready) |-> period_start);

  // R9
  xfer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !period_start |-> $stable(xfer_cnt));

  // R9
  xfer_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_cnt <= XW'(PHASES));

  // R10
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !period_start |-> $stable(seq_err));
endmodule

bind seq5_sequencer seq5_sequencer_chk #(
  .PHASES (PHASES),
  .VW     (VW),
  .XW     (XW)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cmd_valid    (cmd_valid),
  .cmd_ready    (cmd_ready),
  .period_start (period_start),
  .seg_idx      (seg_idx),
  .lvl_out      (lvl_out),
  .xfer_cnt     (xfer_cnt),
  .seq_err      (seq_err)
);

// File: tb/seq5_sequencer_test.sv
`timescale 1ns/1ps
module seq5_sequencer_test;
  localparam int P  = 40;
  localparam int DW = 6;
  localparam int NT = 36;

  typedef struct packed {
    logic [8:0]    a;
    logic [8:0]    b;
    logic [8:0]    c;
    logic [DW-1:0] d1;
    logic [DW-1:0] d2;
    logic [DW-1:0] d3;
  } cmd_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic [8:0]    cmd_vec1 = '0, cmd_vec2 = '0, cmd_vec3 = '0;
  logic [DW-1:0] cmd_dur1 = '0, cmd_dur2 = '0, cmd_dur3 = '0;
  logic [8:0]    lvl_out;
  logic [2:0]    seg_idx;
  logic          period_start;
  logic [1:0]    xfer_cnt;
  logic          seq_err;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  seq5_sequencer #(.PHASES(3), .PERIOD(P)) uut (
    .clk (clk), .rst_n (rst_n),
    .cmd_valid (cmd_valid), .cmd_ready (cmd_ready),
    .cmd_vec1 (cmd_vec1), .cmd_vec2 (cmd_vec2), .cmd_vec3 (cmd_vec3),
    .cmd_dur1 (cmd_dur1), .cmd_dur2 (cmd_dur2), .cmd_dur3 (cmd_dur3),
    .lvl_out (lvl_out), .seg_idx (seg_idx), .period_start (period_start),
    .xfer_cnt (xfer_cnt), .seq_err (seq_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [8:0] v3(input int pa, input int pb, input int pc);
    return {pc[2:0], pb[2:0], pa[2:0]};
  endfunction

  function automatic int seg_of(input cmd_t c, input int i);
    int e1, e2, e3, s1, s2;
    e1 = (int'(c.d1) > P) ? P : int'(c.d1);
    e2 = (int'(c.d2) > P - e1) ? P - e1 : int'(c.d2);
    e3 = P - e1 - e2;
    s1 = e1 / 2;
    s2 = e2 / 2;
    if (i < s1) return 0;
    if (i < s1 + s2) return 1;
    if (i < s1 + s2 + e3) return 2;
    if (i < s1 + s2 + e3 + (e2 - s2)) return 3;
    return 4;
  endfunction

  function automatic logic [8:0] vec_of(input cmd_t c, input int i);
    case (seg_of(c, i))
      1, 3:    return c.b;
      2:       return c.c;
      default: return c.a;
    endcase
  endfunction

  function automatic bit step_ok(input logic [8:0] x, input logic [8:0] y);
    int nd, lx, ly;
    bit bad;
    nd = 0;
    bad = 0;
    for (int p = 0; p < 3; p++) begin
      lx = int'(x[p*3 +: 3]);
      ly = int'(y[p*3 +: 3]);
      if (lx > 4 || ly > 4) bad = 1;
      if (lx != ly) begin
        nd++;
        if (lx - ly != 1 && ly - lx != 1) bad = 1;
      end
    end
    return !bad && nd == 1;
  endfunction

  function automatic int ndiff(input logic [8:0] x, input logic [8:0] y);
    int n;
    n = 0;
    for (int p = 0; p < 3; p++) if (x[p*3 +: 3] != y[p*3 +: 3]) n++;
    return n;
  endfunction

  function automatic logic [8:0] nudge(input logic [8:0] v, input int p);
    int l;
    logic [8:0] r;
    r = v;
    l = int'(v[p*3 +: 3]);
    if (l == 0) l = 1;
    else if (l == 4) l = 3;
    else l = ($urandom % 2 == 0) ? l + 1 : l - 1;
    r[p*3 +: 3] = 3'(l);
    return r;
  endfunction

  function automatic cmd_t rand_cmd();
    cmd_t c;
    int p1, p2, d1, d2;
    c.a = v3($urandom % 5, $urandom % 5, $urandom % 5);
    p1 = $urandom % 3;
    p2 = (p1 + 1 + $urandom % 2) % 3;
    c.b = nudge(c.a, p1);
    c.c = nudge(c.b, p2);
    if ($urandom % 4 != 3) begin
      d1 = $urandom % (P + 1);
      d2 = $urandom % (P + 1 - d1);
      c.d1 = DW'(d1);
      c.d2 = DW'(d2);
      c.d3 = DW'(P - d1 - d2);
    end else begin
      c.d1 = DW'($urandom % 64);
      c.d2 = DW'($urandom % 64);
      c.d3 = DW'($urandom % 64);
    end
    return c;
  endfunction

  function automatic cmd_t mk(input logic [8:0] a, input logic [8:0] b, input logic [8:0] c,
                              input int d1, input int d2, input int d3);
    cmd_t r;
    r.a = a; r.b = b; r.c = c;
    r.d1 = DW'(d1); r.d2 = DW'(d2); r.d3 = DW'(d3);
    return r;
  endfunction

  task automatic drive(input cmd_t c);
    cmd_vec1 = c.a; cmd_vec2 = c.b; cmd_vec3 = c.c;
    cmd_dur1 = c.d1; cmd_dur2 = c.d2; cmd_dur3 = c.d3;
    cmd_valid = 1'b1;
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      report();
      $finish;
    end
  end

  initial begin
    cmd_t cur, nxt, carry;
    bit have, bp, carry_v, exp_err;
    int exp_x;
    string tag;
    logic [8:0] last;

    void'($urandom(32'd20240611));
    cur = mk('0, '0, '0, 0, 0, P);
    exp_err = 0;
    exp_x = 0;
    carry_v = 0;
    carry = cur;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // first cycle after reset, counter at position 0
    chk(lvl_out == 9'd0, "R1 lvl_out", lvl_out, 0);
    chk(seg_idx == 3'd2, "R1 seg_idx", seg_idx, 2);
    chk(xfer_cnt == 2'd0, "R1 xfer_cnt", xfer_cnt, 0);
    chk(seq_err == 1'b0, "R1 seq_err", seq_err, 0);
    chk(cmd_ready == 1'b1, "R1 cmd_ready", cmd_ready, 1);
    chk(period_start == 1'b1, "R1 period_start", period_start, 1);

    for (int t = 0; t < NT; t++) begin
      have = 1;
      bp = 0;
      tag = "R3";
      case (t)
        0: begin nxt = mk(v3(2,1,0), v3(3,1,0), v3(3,2,0), 10, 20, 10); tag = "R11"; end
        1: begin have = 0; tag = "R8"; end
        2: begin nxt = mk(v3(1,1,1), v3(1,2,1), v3(1,2,2), 7, 5, 28); tag = "R4"; end
        3: begin nxt = mk(v3(4,4,4), v3(3,4,4), v3(3,3,4), 0, 0, 40); tag = "R4"; end
        4: begin nxt = mk(v3(0,1,2), v3(0,1,3), v3(1,1,3), 30, 25, 20); tag = "R5"; end
        5: begin nxt = mk(v3(2,2,2), v3(2,3,2), v3(2,3,3), 5, 5, 5); tag = "R5"; end
        6: begin nxt = mk(v3(0,0,0), v3(2,0,0), v3(2,1,0), 12, 8, 20); tag = "R10"; end
        7: begin nxt = mk(v3(5,0,0), v3(4,0,0), v3(4,1,0), 4, 4, 32); tag = "R10"; end
        8: begin nxt = rand_cmd(); bp = 1; tag = "R7"; end
        default: begin
          if (carry_v) nxt = carry;
          else nxt = rand_cmd();
        end
      endcase
      if (t == 9) carry_v = 0;
      if (bp) begin
        carry = rand_cmd();
        carry_v = 1;
      end

      // position 0 of the current period
      chk(period_start == 1'b1, "R2 start", period_start, 1);
      chk(int'(xfer_cnt) == exp_x, "R9 xfer_cnt", xfer_cnt, exp_x);
      chk(seq_err == exp_err, "R10 seq_err", seq_err, exp_err);

      for (int i = 0; i < P; i++) begin
        if (i > 0) @(negedge clk);
        if (i == 0 && have) drive(nxt);
        if (i == 1 && have) begin
          chk(cmd_ready == 1'b0, "R7 ready after accept", cmd_ready, 0);
          cmd_valid = 1'b0;
        end
        if (i == 2 && bp) drive(carry);
        if (i == P - 1 && bp) chk(cmd_ready == 1'b0, "R7 held while full", cmd_ready, 0);
        if (i > 0) chk(period_start == 1'b0, "R2 strobe", period_start, 0);
        chk(lvl_out == vec_of(cur, i), tag, lvl_out, vec_of(cur, i));
        chk(int'(seg_idx) == seg_of(cur, i), "R3 seg_idx", seg_idx, seg_of(cur, i));
        if (i == P - 1 && have)
          chk(lvl_out == vec_of(cur, i), "R6 old program kept", lvl_out, vec_of(cur, i));
      end
      last = vec_of(cur, P - 1);
      if (have) begin
        cur = nxt;
        exp_err = !(step_ok(cur.a, cur.b) && step_ok(cur.b, cur.c));
      end
      exp_x = ndiff(last, vec_of(cur, 0));
      @(negedge clk);
    end

    done = 1'b1;
    report();
    $finish;
  end
endmodule